// File: doc/BRIEF.md
# Cumulative Arrow Warning Sign Sequencer

This block steps a five-lamp arrow warning sign through a repeating build-up pattern. The sign starts dark. It then lights the first pair of lamps, then both pairs, then both pairs and the arrow tip, and then returns to dark. The cycle runs for as long as the operator switch is on.

The lamps are driven as three groups:
- the low pair (lamps 1 and 2);
- the high pair (lamps 3 and 4);
- the tip (lamp 5).

A 2-bit phase register holds the position in the pattern. The groups decode from that register alone.

A one-cycle `tick` strobe from an external rate divider sets the blink rate. The register changes only on a tick. On a tick with the switch on, the register moves one phase forward. On a tick with the switch off, the register goes to the dark phase.

Top module: `warnsign_top`

## Requirements
- R1: After reset is asserted (rst_n low), the phase is 00 and all three lamp outputs are 0.
- R2: On a clock edge with tick high and switchOn high, the phase moves forward by exactly one: 00 to 01, 01 to 10, 10 to 11.
- R3: On a tick with switchOn high, phase 11 (all lamps lit) is followed by phase 00 (dark).
- R4: On a clock edge with tick low, the phase and all lamp outputs keep their values, whatever switchOn is.
- R5: On a clock edge with tick high and switchOn low, the next phase is 00 (dark), from any phase.
- R6: The lamp outputs decode from the phase as follows:
  - 00: all three outputs off;
  - 01: lampPairLow on;
  - 10: lampPairLow and lampPairHigh on;
  - 11: all three outputs on.
  
  The outputs light cumulatively, so lampTip implies lampPairHigh, and lampPairHigh implies lampPairLow.
- R7: The lamp outputs depend only on the stored phase. A change on switchOn alone, with no tick, leaves them unchanged.
- R8: With tick held high for several cycles in a row, the pattern moves one phase per cycle and skips no phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Step-rate strobe; the phase updates only on cycles where it is high |
| switchOn | input | 1 | Operator switch; 1 runs the pattern, 0 sends the sign dark on the next tick |
| lampPairLow | output | 1 | Drives lamps 1 and 2 |
| lampPairHigh | output | 1 | Drives lamps 3 and 4 |
| lampTip | output | 1 | Drives lamp 5 |

## Verification
The hardest case to reach is switch-off from the fully lit phase. It needs three ticks in a row with the switch on, and then a tick with the switch off. A stepped stimulus table gets there, and it also turns the switch off from the middle phases.

A second hard case is a switch change with no tick. It must leave the lamps alone, which proves they do not follow the switch. The table toggles switchOn on non-tick cycles while the sign is partly lit.

// File: rtl/warnsign_pkg.sv
package warnsign_pkg;
  // Control-to-datapath strobes for the phase register.
  typedef struct packed {
    logic step;   // advance one phase
    logic clear;  // force dark phase
  } seqStrobes_t;
endpackage

// File: rtl/warnsign_ctrl.sv
module warnsign_ctrl
  import warnsign_pkg::*;
(
  input  logic        tick,
  input  logic        switchOn,
  output seqStrobes_t strobes
);
  // A tick either advances the pattern or darkens the sign.
  always_comb begin
    strobes.step  = tick & switchOn;
    strobes.clear = tick & ~switchOn;
  end
endmodule

// File: rtl/warnsign_dp.sv
module warnsign_dp
  import warnsign_pkg::*;
#(
  parameter int PhaseW    = 2,
  parameter int NumGroups = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  seqStrobes_t          strobes,
  output logic [NumGroups-1:0] lampVec
);
  localparam logic [PhaseW-1:0] DarkPhase = '0;

  logic [PhaseW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase <= DarkPhase;
    else if (strobes.clear)  phase <= DarkPhase;
    else if (strobes.step)   phase <= phase + 1'b1;
  end

  // Group g lights once the phase passes g: a cumulative build-up.
  for (genvar g = 0; g < NumGroups; g++) begin : gLamp
    assign lampVec[g] = (phase > PhaseW'(g));
    if (g > 0) begin : gOrder
      AST_LAMP_CUMULATIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lampVec[g] |-> lampVec[g-1]);                                   // R6
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.step && !strobes.clear) |=> $stable(phase));              // R4
  AST_CLEAR_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clear |=> (phase == DarkPhase));                            // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.step |=> (phase == PhaseW'($past(phase) + 1'b1)));          // R2
  AST_WRAP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.step && (&phase)) |=> (phase == DarkPhase));               // R3
endmodule

// File: rtl/warnsign_top.sv
module warnsign_top
  import warnsign_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic switchOn,
  output logic lampPairLow,
  output logic lampPairHigh,
  output logic lampTip
);
  localparam int PhaseW    = 2;
  localparam int NumGroups = 3;

  seqStrobes_t          strobes;
  logic [NumGroups-1:0] lampVec;

  warnsign_ctrl u_ctrl (
    .tick     (tick),
    .switchOn (switchOn),
    .strobes  (strobes)
  );

  warnsign_dp #(.PhaseW(PhaseW), .NumGroups(NumGroups)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .lampVec (lampVec)
  );

  assign lampPairLow  = lampVec[0];
  assign lampPairHigh = lampVec[1];
  assign lampTip      = lampVec[2];
endmodule

// File: tb/sim_warnsign_top.sv
module sim_warnsign_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic switchOn = 1'b0;
  logic lampPairLow, lampPairHigh, lampTip;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  warnsign_top u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .switchOn(switchOn),
    .lampPairLow(lampPairLow), .lampPairHigh(lampPairHigh), .lampTip(lampTip)
  );

  // Each row holds {tick, switchOn, expected {tip, high, low}} and the requirement it exercises.
  localparam int NumVec = 14;
  localparam logic [4:0] Vecs [NumVec] = '{
    5'b11_001,  // R2 00->01
    5'b01_001,  // R4 no tick holds
    5'b11_011,  // R2 01->10
    5'b00_011,  // R7 switch off, no tick
    5'b11_111,  // R2 10->11
    5'b11_000,  // R3 wrap to dark
    5'b11_001,  // R2
    5'b11_011,  // R2
    5'b10_000,  // R5 off from 10
    5'b10_000,  // R5 stays dark
    5'b11_001,  // R2
    5'b11_011,  // R2
    5'b11_111,  // R6 all lit
    5'b10_000   // R5 off from 11
  };
  localparam int VecReq [NumVec] = '{2, 4, 2, 7, 2, 3, 2, 2, 5, 5, 2, 2, 6, 5};

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] got;
    got = {lampTip, lampPairHigh, lampPairLow};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s lamps got %b expected %b", req, got, exp);
    end
  endtask

  // Drive at the falling edge, then sample 1 ns after the rising edge.
  task automatic cycle(input logic t, input logic s);
    @(negedge clk);
    tick = t;
    switchOn = s;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #5;
    check("R1", 3'b000);  // during reset
    @(negedge clk);
    rst_n = 1'b1;
    cycle(1'b0, 1'b0);
    check("R1", 3'b000);

    for (int i = 0; i < NumVec; i++) begin
      cycle(Vecs[i][4], Vecs[i][3]);
      check($sformatf("R%0d row %0d", VecReq[i], i), Vecs[i][2:0]);
    end

    // R8: tick held high, one phase per cycle.
    cycle(1'b1, 1'b1); check("R8", 3'b001);
    cycle(1'b1, 1'b1); check("R8", 3'b011);
    cycle(1'b1, 1'b1); check("R8", 3'b111);
    cycle(1'b1, 1'b1); check("R8", 3'b000);

    // R7: toggle the switch with no tick while partly lit.
    cycle(1'b1, 1'b1); check("R2", 3'b001);
    cycle(1'b0, 1'b0); check("R7", 3'b001);
    cycle(1'b0, 1'b1); check("R7", 3'b001);
    cycle(1'b0, 1'b0); check("R4", 3'b001);

    // R1: reset in the middle of a run.
    cycle(1'b1, 1'b1); cycle(1'b1, 1'b1); check("R2", 3'b111);
    @(negedge clk);
    rst_n = 1'b0;
    tick = 1'b0;
    #1;
    check("R1", 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    cycle(1'b1, 1'b1); check("R2", 3'b001);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule